// File: doc/BRIEF.md
# IP Header Exception Classifier

The classifier watches a received frame as a byte stream. The frame's link-layer header runs for a byte count given with the first byte, and the classifier skips it. It then inspects the network-layer header that follows. For each frame it decides whether the packet is usable IPv4 or IPv6. When it is not, it reports one first-level exception code. The rule is a fixed priority: a receive error flagged by the MAC comes first, then a version that is not IP, then header and length exceptions, then fragment status.

Bytes come with a valid qualifier and first and last markers, and gaps between bytes are allowed. The block holds only the few header bytes it needs and a running one's-complement sum. One clock after the last byte of every frame it raises a result strobe for a single cycle, together with the flags and the code. This holds even when the frame is too short to contain a header. The checks cover IPv4 options through the header-length field. IPv6 is checked for its fixed 40-byte header only.

Top module: `ip_hdr_classifier`

## Requirements
- R1: `res_valid_o` is high for exactly one cycle, in the cycle after the clock edge that accepts a byte with `byte_valid_i` and `eof_i` both high, and is low in every other cycle, for frames of any length and with idle cycles between bytes.
- R2: The IP header begins at byte index `l2_len_i` of the frame (index 0 is the byte marked `sof_i`). `l2_len_i` is sampled only with the `sof_i` byte, and bytes before that index do not affect the result.
- R3: If `rx_err_i` is high on any accepted byte of a frame, the result is `not_ip=1`, `ip_exc=0`, `is_v6=0`, `is_frag=0`, code 0, whatever the bytes hold.
- R4: If the high nibble of the first IP byte is neither 4 nor 6, the result is `not_ip=1`, `ip_exc=0`, code 1.
- R5: Code 3 with `ip_exc=1` is reported when the frame holds no IP byte, when an IPv4 header-length field (low nibble of the first IP byte) is below 5, or when the frame ends before the full header (4 × that field bytes for IPv4, 40 bytes for IPv6).
- R6: Code 2 with `ip_exc=1` is reported when the one's-complement sum of the IPv4 header's 16-bit big-endian words is not 0xFFFF.
- R7: Code 4 with `ip_exc=1` is reported when fewer IP bytes arrive than the length field asks for: IP bytes 2–3 give the total length for IPv4, and 40 plus IP bytes 4–5 give it for IPv6. Bytes beyond that length are pad and are accepted.
- R8: Code 5 with `ip_exc=1` is reported when the IPv4 TTL (IP byte 8) or the IPv6 hop limit (IP byte 7) is zero.
- R9: Among IP exceptions the order is code 3, then 2, then 4, then 5. Only the first that applies is reported.
- R10: `is_frag` is set only for an IPv4 packet with no exception when the more-fragments bit (bit 5 of IP byte 6) is set or the 13-bit fragment offset (bits 4:0 of IP byte 6 with IP byte 7) is nonzero. Bits 7:6 of IP byte 6 are ignored, and IPv6 never sets it.
- R11: A packet that passes every check reports code 0 with `not_ip=0` and `ip_exc=0`. `is_v6` is set whenever the version is 6 and no receive error is present, exceptions included.
- R12: While `rst_ni` is low, `res_valid_o` and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | A frame byte is present this cycle |
| byte_i | input | 8 | Frame byte |
| sof_i | input | 1 | First byte of a frame (qualified by valid) |
| eof_i | input | 1 | Last byte of a frame (qualified by valid) |
| l2_len_i | input | L2_W | Link-layer header length in bytes, sampled with the first byte |
| rx_err_i | input | 1 | Receive error from the MAC, on any byte |
| res_valid_o | output | 1 | Result strobe, one cycle per frame |
| res_is_v6_o | output | 1 | Packet version is 6 |
| res_not_ip_o | output | 1 | Receive error or non-IP version |
| res_ip_exc_o | output | 1 | IP exception, code in `res_code_o` |
| res_is_frag_o | output | 1 | Clean IPv4 fragment |
| res_code_o | output | 4 | First-level exception code (0 none, 1–5) |

## Verification
On every cycle the assertions check the placement of the strobe against the last byte, that `not_ip` and `ip_exc` never appear together, that each flag carries a code from its own set, that a fragment is only reported on a clean IPv4 result, that a receive error on the final byte forces the non-IP result, and that bytes ahead of the IP header leave the captured fields alone. Which code a given byte pattern earns cannot be seen from the outputs alone: the priority between a bad checksum, a short length and a zero TTL, pad tolerance, options through a larger header length, truncation at every layer, and the sampling of the link-layer length only at the first byte. The bench scenarios show these by comparing each frame with an independent model.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int unsigned CAP_N       = 9;   // IP bytes 0..8 are captured
  localparam int unsigned V4_MIN_IHL  = 5;
  localparam int unsigned V6_HDR_LEN  = 40;
  localparam int unsigned OFS_V4_LEN  = 2;
  localparam int unsigned OFS_V6_PLEN = 4;
  localparam int unsigned OFS_FRAG    = 6;
  localparam int unsigned OFS_V6_HOP  = 7;
  localparam int unsigned OFS_V4_TTL  = 8;

  typedef enum logic [3:0] {
    ERR_NONE      = 4'd0,
    ERR_NOT_IP    = 4'd1,
    ERR_HDR_CSUM  = 4'd2,
    ERR_HDR_SHORT = 4'd3,
    ERR_LEN_SHORT = 4'd4,
    ERR_TTL_ZERO  = 4'd5
  } ip_err_e;

  typedef struct packed {
    logic    is_v6;
    logic    not_ip;
    logic    ip_exc;
    logic    is_frag;
    ip_err_e code;
  } ip_verdict_t;
endpackage

// File: rtl/ipc_pos_track.sv
module ipc_pos_track #(
  parameter int unsigned CNT_W = 17,
  parameter int unsigned L2_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic [L2_W-1:0]  l2_len_i,
  input  logic             rx_err_i,
  output logic             in_ip_o,
  output logic [CNT_W-1:0] ip_idx_o,
  output logic [CNT_W-1:0] ip_cnt_o,
  output logic             rx_err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] pos_q, cur_pos, pos_d, l2_ext;
  logic [L2_W-1:0]  l2_q, cur_l2;
  logic             rx_q, rx_d;

  always_comb begin
    cur_pos  = sof_i ? '0 : pos_q;
    cur_l2   = sof_i ? l2_len_i : l2_q;
    l2_ext   = CNT_W'(cur_l2);
    pos_d    = (cur_pos == CNT_MAX) ? cur_pos : cur_pos + 1'b1;
    in_ip_o  = cur_pos >= l2_ext;
    ip_idx_o = cur_pos - l2_ext;
    // IP bytes seen including the current one; saturates with the position
    ip_cnt_o = in_ip_o ? (pos_d - l2_ext) : '0;
    rx_d     = (sof_i ? 1'b0 : rx_q) | rx_err_i;
    rx_err_o = rx_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      l2_q  <= '0;
      rx_q  <= 1'b0;
    end else if (valid_i) begin
      pos_q <= pos_d;
      l2_q  <= cur_l2;
      rx_q  <= rx_d;
    end
  end

  p_pos_mono_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sof_i) |=> (pos_q >= $past(pos_q)));

  p_l2_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sof_i) |=> (l2_q == $past(l2_q)));
endmodule

// File: rtl/ipc_hdr_capture.sv
module ipc_hdr_capture
  import ipc_pkg::*;
#(
  parameter int unsigned CNT_W = 17
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic                       sof_i,
  input  logic                       in_ip_i,
  input  logic [CNT_W-1:0]           ip_idx_i,
  input  logic [7:0]                 byte_i,
  output logic [CAP_N-1:0][7:0]      cap_o
);
  logic [CAP_N-1:0][7:0] cap_q, cap_d;

  for (genvar k = 0; k < CAP_N; k++) begin : g_cap
    logic hit;
    always_comb begin
      hit      = valid_i && in_ip_i && (ip_idx_i == CNT_W'(k));
      cap_d[k] = hit ? byte_i : (sof_i ? 8'h00 : cap_q[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cap_q <= '0;
    else if (valid_i) cap_q <= cap_d;
  end

  assign cap_o = cap_d;

  p_pre_ip_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sof_i && !in_ip_i) |=> (cap_q == $past(cap_q)));
endmodule

// File: rtl/ipc_csum_acc.sv
module ipc_csum_acc #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             in_ip_i,
  input  logic [CNT_W-1:0] ip_idx_i,
  input  logic [7:0]       byte_i,
  input  logic [3:0]       ihl_i,
  output logic             ok_o
);
  // at most 30 words of 16 bits: 21 bits hold the raw sum
  localparam int unsigned ACC_W = 21;

  logic [ACC_W-1:0] acc_q, acc_d, acc_base;
  logic [15:0]      word;
  logic [CNT_W-1:0] hlen;
  logic             take;
  logic [16:0]      fold1, fold2;

  always_comb begin
    hlen     = CNT_W'({ihl_i, 2'b00});
    take     = valid_i && in_ip_i && (ip_idx_i < hlen);
    word     = ip_idx_i[0] ? {8'h00, byte_i} : {byte_i, 8'h00};
    acc_base = sof_i ? '0 : acc_q;
    acc_d    = acc_base + (take ? ACC_W'(word) : '0);
    fold1    = 17'(acc_d[15:0]) + 17'(acc_d[ACC_W-1:16]);
    fold2    = 17'(fold1[15:0]) + 17'(fold1[16]);
    ok_o     = (fold2[15:0] == 16'hFFFF);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (valid_i) acc_q <= acc_d;
  end

  p_acc_grow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sof_i) |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/ipc_verdict.sv
module ipc_verdict
  import ipc_pkg::*;
#(
  parameter int unsigned CNT_W = 17
) (
  input  logic                  rx_err_i,
  input  logic [CNT_W-1:0]      ip_cnt_i,
  input  logic [CAP_N-1:0][7:0] cap_i,
  input  logic                  csum_ok_i,
  output ip_verdict_t           verdict_o
);
  logic [3:0]       ver, ihl;
  logic [CNT_W-1:0] v4_hlen, v4_total, v6_total;
  logic             frag_hit, unused_cap;

  always_comb begin
    ver      = cap_i[0][7:4];
    ihl      = cap_i[0][3:0];
    v4_hlen  = CNT_W'({ihl, 2'b00});
    v4_total = CNT_W'({cap_i[OFS_V4_LEN], cap_i[OFS_V4_LEN+1]});
    v6_total = CNT_W'(V6_HDR_LEN) + CNT_W'({cap_i[OFS_V6_PLEN], cap_i[OFS_V6_PLEN+1]});
    frag_hit = cap_i[OFS_FRAG][5] || (|cap_i[OFS_FRAG][4:0]) || (|cap_i[OFS_FRAG+1]);
  end

  assign unused_cap = ^{cap_i[1], cap_i[OFS_FRAG][7:6]};

  always_comb begin
    verdict_o = '0;
    if (rx_err_i) begin
      verdict_o.not_ip = 1'b1;
    end else if (ip_cnt_i == '0) begin
      verdict_o.ip_exc = 1'b1;
      verdict_o.code   = ERR_HDR_SHORT;
    end else if (ver == 4'd6) begin
      verdict_o.is_v6 = 1'b1;
      if (ip_cnt_i < CNT_W'(V6_HDR_LEN)) begin
        verdict_o.ip_exc = 1'b1;
        verdict_o.code   = ERR_HDR_SHORT;
      end else if (ip_cnt_i < v6_total) begin
        verdict_o.ip_exc = 1'b1;
        verdict_o.code   = ERR_LEN_SHORT;
      end else if (cap_i[OFS_V6_HOP] == 8'h00) begin
        verdict_o.ip_exc = 1'b1;
        verdict_o.code   = ERR_TTL_ZERO;
      end
    end else if (ver == 4'd4) begin
      if (ihl < 4'(V4_MIN_IHL) || ip_cnt_i < v4_hlen) begin
        verdict_o.ip_exc = 1'b1;
        verdict_o.code   = ERR_HDR_SHORT;
      end else if (!csum_ok_i) begin
        verdict_o.ip_exc = 1'b1;
        verdict_o.code   = ERR_HDR_CSUM;
      end else if (ip_cnt_i < v4_total) begin
        verdict_o.ip_exc = 1'b1;
        verdict_o.code   = ERR_LEN_SHORT;
      end else if (cap_i[OFS_V4_TTL] == 8'h00) begin
        verdict_o.ip_exc = 1'b1;
        verdict_o.code   = ERR_TTL_ZERO;
      end else begin
        verdict_o.is_frag = frag_hit;
      end
    end else begin
      verdict_o.not_ip = 1'b1;
      verdict_o.code   = ERR_NOT_IP;
    end
  end
endmodule

// File: rtl/ip_hdr_classifier.sv
module ip_hdr_classifier
  import ipc_pkg::*;
#(
  parameter int unsigned L2_W  = 8,
  parameter int unsigned CNT_W = 17   // must exceed L2_W and be at least 17
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            byte_valid_i,
  input  logic [7:0]      byte_i,
  input  logic            sof_i,
  input  logic            eof_i,
  input  logic [L2_W-1:0] l2_len_i,
  input  logic            rx_err_i,
  output logic            res_valid_o,
  output logic            res_is_v6_o,
  output logic            res_not_ip_o,
  output logic            res_ip_exc_o,
  output logic            res_is_frag_o,
  output logic [3:0]      res_code_o
);
  logic                  in_ip, rx_err_d, csum_ok;
  logic [CNT_W-1:0]      ip_idx, ip_cnt;
  logic [CAP_N-1:0][7:0] cap;
  ip_verdict_t           verdict, res_q;
  logic                  res_valid_q;

  ipc_pos_track #(.CNT_W(CNT_W), .L2_W(L2_W)) u_pos (
    .clk_i, .rst_ni,
    .valid_i  (byte_valid_i),
    .sof_i    (sof_i),
    .l2_len_i (l2_len_i),
    .rx_err_i (byte_valid_i && rx_err_i),
    .in_ip_o  (in_ip),
    .ip_idx_o (ip_idx),
    .ip_cnt_o (ip_cnt),
    .rx_err_o (rx_err_d)
  );

  ipc_hdr_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i, .rst_ni,
    .valid_i  (byte_valid_i),
    .sof_i    (sof_i),
    .in_ip_i  (in_ip),
    .ip_idx_i (ip_idx),
    .byte_i   (byte_i),
    .cap_o    (cap)
  );

  ipc_csum_acc #(.CNT_W(CNT_W)) u_csum (
    .clk_i, .rst_ni,
    .valid_i  (byte_valid_i),
    .sof_i    (sof_i),
    .in_ip_i  (in_ip),
    .ip_idx_i (ip_idx),
    .byte_i   (byte_i),
    .ihl_i    (cap[0][3:0]),
    .ok_o     (csum_ok)
  );

  ipc_verdict #(.CNT_W(CNT_W)) u_verdict (
    .rx_err_i  (rx_err_d),
    .ip_cnt_i  (ip_cnt),
    .cap_i     (cap),
    .csum_ok_i (csum_ok),
    .verdict_o (verdict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_q       <= '0;
    end else begin
      res_valid_q <= byte_valid_i && eof_i;
      if (byte_valid_i && eof_i) res_q <= verdict;
    end
  end

  assign res_valid_o   = res_valid_q;
  assign res_is_v6_o   = res_q.is_v6;
  assign res_not_ip_o  = res_q.not_ip;
  assign res_ip_exc_o  = res_q.ip_exc;
  assign res_is_frag_o = res_q.is_frag;
  assign res_code_o    = res_q.code;

  p_strobe_after_eof_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && eof_i) |=> res_valid_o);

  p_strobe_only_eof_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_valid_i && eof_i) |=> !res_valid_o);

  p_rx_override_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && eof_i && rx_err_i) |=>
      (res_not_ip_o && !res_ip_exc_o && res_code_o == 4'd0));

  p_flag_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !(res_not_ip_o && res_ip_exc_o));

  p_not_ip_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_not_ip_o) |->
      (res_code_o <= 4'd1 && !res_is_v6_o && !res_is_frag_o));

  p_exc_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_ip_exc_o) |-> (res_code_o >= 4'd2 && res_code_o <= 4'd5));

  p_frag_clean_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_is_frag_o) |-> (!res_not_ip_o && !res_ip_exc_o && !res_is_v6_o));

  p_pass_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_not_ip_o && !res_ip_exc_o) |-> (res_code_o == 4'd0));
endmodule

// File: tb/tb_ip_hdr_classifier.sv
`timescale 1ns/1ps
module tb_ip_hdr_classifier;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bv = 1'b0, sof = 1'b0, eof = 1'b0, rxe = 1'b0;
  logic [7:0] byt = 8'h00;
  logic [7:0] l2_len = 8'h00;
  logic       res_valid, res_v6, res_ni, res_ex, res_fr;
  logic [3:0] res_code;

  always #2.5 clk = ~clk;

  ip_hdr_classifier dut (
    .clk_i(clk), .rst_ni(rst_n),
    .byte_valid_i(bv), .byte_i(byt), .sof_i(sof), .eof_i(eof),
    .l2_len_i(l2_len), .rx_err_i(rxe),
    .res_valid_o(res_valid), .res_is_v6_o(res_v6), .res_not_ip_o(res_ni),
    .res_ip_exc_o(res_ex), .res_is_frag_o(res_fr), .res_code_o(res_code)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit run = 0, done = 0;

  // ---------------- reference model ----------------
  logic [7:0] mq[$];
  int    l2m;
  bit    rxm, exp_v;
  bit    e_v6, e_ni, e_ex, e_fr;
  int    e_cd;
  string e_tag;
  string tagq[$];

  task automatic model();
    int n, ipn, b, ver, ihl, s, tot, plen;
    n = mq.size(); b = l2m;
    ipn = (n > l2m) ? n - l2m : 0;
    e_v6 = 0; e_ni = 0; e_ex = 0; e_fr = 0; e_cd = 0;
    if (rxm) e_ni = 1;
    else if (ipn == 0) begin e_ex = 1; e_cd = 3; end
    else begin
      ver = int'(mq[b]) >> 4;
      ihl = int'(mq[b]) & 15;
      if (ver == 6) begin
        e_v6 = 1;
        if (ipn < 40) begin e_ex = 1; e_cd = 3; end
        else begin
          plen = int'(mq[b+4]) * 256 + int'(mq[b+5]);
          if (ipn < 40 + plen) begin e_ex = 1; e_cd = 4; end
          else if (mq[b+7] == 0) begin e_ex = 1; e_cd = 5; end
        end
      end else if (ver == 4) begin
        if (ihl < 5 || ipn < ihl * 4) begin e_ex = 1; e_cd = 3; end
        else begin
          s = 0;
          for (int w = 0; w < ihl * 2; w++) s += int'(mq[b+2*w]) * 256 + int'(mq[b+2*w+1]);
          while (s > 65535) s = (s & 65535) + (s >> 16);
          tot = int'(mq[b+2]) * 256 + int'(mq[b+3]);
          if (s != 65535) begin e_ex = 1; e_cd = 2; end
          else if (ipn < tot) begin e_ex = 1; e_cd = 4; end
          else if (mq[b+8] == 0) begin e_ex = 1; e_cd = 5; end
          else e_fr = ((mq[b+6] & 8'h3F) != 0) || (mq[b+7] != 0);
        end
      end else begin e_ni = 1; e_cd = 1; end
    end
  endtask

  always @(posedge clk) begin
    exp_v = 0;
    if (rst_n && bv) begin
      if (sof) begin mq.delete(); l2m = int'(l2_len); rxm = 0; end
      mq.push_back(byt);
      if (rxe) rxm = 1;
      if (eof) begin model(); e_tag = tagq.pop_front(); exp_v = 1; end
    end
  end

  // ---------------- comparison on every clock ----------------
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got cycle %0d exp below 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n && run) begin
      checks++;
      if (res_valid !== exp_v) begin
        errors++;
        $display("FAIL R1 strobe: got %0b exp %0b at cycle %0d", res_valid, exp_v, cyc);
      end else if (exp_v) begin
        checks++;
        if (res_v6 !== e_v6 || res_ni !== e_ni || res_ex !== e_ex ||
            res_fr !== e_fr || int'(res_code) != e_cd) begin
          errors++;
          $display("FAIL %s result: got v6=%0b nip=%0b exc=%0b frag=%0b code=%0d exp v6=%0b nip=%0b exc=%0b frag=%0b code=%0d",
                   e_tag, res_v6, res_ni, res_ex, res_fr, res_code,
                   e_v6, e_ni, e_ex, e_fr, e_cd);
        end
      end
    end
  end

  // ---------------- frame construction ----------------
  logic [7:0] fb[$];
  int fl2;

  task automatic start(int l2);
    fb.delete(); fl2 = l2;
    for (int i = 0; i < l2; i++) fb.push_back(8'(8'hC3 ^ i));
  endtask

  task automatic add_v4(int ihl, int ttl, int f6, int f7, int pay, int pad);
    int hs, tot, s;
    hs = fb.size(); tot = ihl * 4 + pay; s = 0;
    fb.push_back(8'(8'h40 | ihl)); fb.push_back(8'h00);
    fb.push_back(8'(tot >> 8));    fb.push_back(8'(tot & 255));
    fb.push_back(8'h12); fb.push_back(8'h34);
    fb.push_back(8'(f6)); fb.push_back(8'(f7));
    fb.push_back(8'(ttl)); fb.push_back(8'h11);
    fb.push_back(8'h00); fb.push_back(8'h00);
    for (int i = 12; i < ihl * 4; i++) fb.push_back(8'(i * 13 + 5));
    for (int w = 0; w < ihl * 2; w++) s += int'(fb[hs+2*w]) * 256 + int'(fb[hs+2*w+1]);
    while (s > 65535) s = (s & 65535) + (s >> 16);
    s = (~s) & 16'hFFFF;
    fb[hs+10] = 8'(s >> 8); fb[hs+11] = 8'(s & 255);
    for (int i = 0; i < pay; i++) fb.push_back(8'(i + 1));
    for (int i = 0; i < pad; i++) fb.push_back(8'h00);
  endtask

  task automatic add_v6(int pay, int hop, int pad);
    fb.push_back(8'h60); fb.push_back(8'h00); fb.push_back(8'h00); fb.push_back(8'h00);
    fb.push_back(8'(pay >> 8)); fb.push_back(8'(pay & 255));
    fb.push_back(8'h3A); fb.push_back(8'(hop));
    for (int i = 0; i < 32; i++) fb.push_back(8'(i * 3 + 7));
    for (int i = 0; i < pay; i++) fb.push_back(8'(i + 9));
    for (int i = 0; i < pad; i++) fb.push_back(8'h00);
  endtask

  task automatic trunc(int k);
    repeat (k) void'(fb.pop_back());
  endtask

  task automatic idle();
    bv = 0; sof = 0; eof = 0; rxe = 0; byt = 8'h00;
  endtask

  // l2_len is presented only with the first byte; other values follow (R2)
  task automatic send(string tag, int rx_at, int gap, int tail);
    int n;
    n = fb.size();
    tagq.push_back(tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bv = 1; byt = fb[i]; sof = (i == 0); eof = (i == n - 1); rxe = (i == rx_at);
      l2_len = (i == 0) ? 8'(fl2) : 8'(fl2 ^ 9);
      if (gap > 0 && i < n - 1) begin
        @(negedge clk); idle();
        repeat (gap - 1) @(negedge clk);
      end
    end
    if (tail > 0) begin
      @(negedge clk); idle();
      repeat (tail - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: outputs quiet while reset is held
    checks++;
    if (res_valid !== 1'b0 || res_code !== 4'd0 || res_ni !== 1'b0 || res_ex !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset: got valid=%0b code=%0d exp valid=0 code=0", res_valid, res_code);
    end
    rst_n = 1;
    run = 1;
    repeat (2) @(negedge clk);

    start(14); add_v4(5, 64, 0, 0, 10, 0); send("R11", -1, 0, 2);
    start(14); add_v4(5, 64, 0, 0, 10, 6); send("R7", -1, 0, 2);
    start(14); add_v6(8, 1, 0);            send("R11", -1, 0, 2);
    start(0);  add_v4(5, 9, 0, 0, 3, 0);   send("R2", -1, 0, 2);
    start(22); add_v6(4, 2, 3);            send("R2", -1, 0, 2);
    start(14); add_v4(6, 64, 0, 0, 4, 0);  send("R11", -1, 0, 2);
    start(14); add_v4(15, 64, 0, 0, 2, 0); send("R11", -1, 0, 2);
    // R4
    start(14); add_v4(5, 64, 0, 0, 10, 0); fb[fl2] = 8'h55; send("R4", -1, 0, 2);
    start(0);  add_v4(5, 64, 0, 0, 2, 0);  fb[fl2] = 8'h05; send("R4", -1, 0, 2);
    // R3
    start(14); add_v4(5, 64, 0, 0, 10, 0); fb[fl2+13] ^= 8'h01; send("R3", 3, 0, 2);
    start(14); add_v6(8, 0, 0); send("R3", fb.size() - 1, 0, 2);
    start(14); add_v4(5, 64, 8'h20, 0, 4, 0); send("R3", 20, 0, 2);
    // R5
    start(14); add_v4(5, 64, 0, 0, 10, 0); trunc(18); send("R5", -1, 0, 2);
    start(14); trunc(9); send("R5", -1, 0, 2);
    start(0);  fb.push_back(8'h45); send("R5", -1, 0, 2);
    start(14); add_v4(5, 64, 0, 0, 10, 0); fb[fl2] = 8'h44; send("R5", -1, 0, 2);
    start(14); add_v4(6, 64, 0, 0, 4, 0); trunc(6); send("R5", -1, 0, 2);
    start(14); add_v6(8, 5, 0); trunc(18); send("R5", -1, 0, 2);
    // R6
    start(14); add_v4(5, 64, 0, 0, 10, 0); fb[fl2+13] ^= 8'h01; send("R6", -1, 0, 2);
    start(14); add_v4(6, 64, 0, 0, 4, 0); fb[fl2+21] ^= 8'h80; send("R6", -1, 0, 2);
    // R7
    start(14); add_v4(5, 64, 0, 0, 10, 0); trunc(2); send("R7", -1, 0, 2);
    start(14); add_v6(8, 5, 0); trunc(1); send("R7", -1, 0, 2);
    start(14); add_v6(8, 5, 9); send("R7", -1, 0, 2);
    // R8
    start(14); add_v4(5, 0, 0, 0, 10, 0); send("R8", -1, 0, 2);
    start(14); add_v6(8, 0, 0); send("R8", -1, 0, 2);
    // R9
    start(14); add_v4(5, 0, 0, 0, 10, 0); fb[fl2+13] ^= 8'h01; send("R9", -1, 0, 2);
    start(14); add_v4(5, 0, 0, 0, 10, 0); trunc(3); send("R9", -1, 0, 2);
    start(14); add_v4(5, 64, 0, 0, 10, 0); trunc(3); fb[fl2+13] ^= 8'h04; send("R9", -1, 0, 2);
    start(14); add_v4(5, 0, 0, 0, 10, 0); fb[fl2] = 8'h44; send("R9", -1, 0, 2);
    start(14); add_v6(8, 0, 0); trunc(2); send("R9", -1, 0, 2);
    // R10
    start(14); add_v4(5, 64, 8'h20, 0, 10, 0); send("R10", -1, 0, 2);
    start(14); add_v4(5, 64, 0, 8'h01, 10, 0); send("R10", -1, 0, 2);
    start(14); add_v4(5, 64, 8'h01, 0, 10, 0); send("R10", -1, 0, 2);
    start(14); add_v4(5, 64, 8'h40, 0, 10, 0); send("R10", -1, 0, 2);
    start(14); add_v4(5, 0, 8'h20, 0, 10, 0); send("R10", -1, 0, 2);
    start(14); add_v4(5, 64, 8'h20, 0, 10, 0); fb[fl2+13] ^= 8'h01; send("R10", -1, 0, 2);
    // R1: idle gaps inside a frame, and frames back to back
    start(14); add_v4(5, 64, 0, 0, 6, 0); send("R1", -1, 2, 0);
    start(4);  add_v6(2, 3, 0); send("R1", -1, 0, 0);
    start(0);  fb.push_back(8'h60); send("R1", -1, 0, 0);
    start(2);  add_v4(5, 64, 0, 0, 0, 0); send("R1", -1, 1, 3);

    repeat (4) @(negedge clk);
    run = 0; done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule